// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After reset this block reads a fixed-length configuration image out of an external serial EEPROM over a three-wire command/data link with chip select. Each 16-bit word arrives most significant bit first. The first few words fill a small address store. The remaining words go into shadow copies of the programmable configuration registers. While the words arrive, the block keeps an 8-bit running sum of every image byte.

When the last word is in, the block accepts the image only if that byte sum equals FFh. The final byte of the image is an adjust byte that the image builder chooses to make this true. On success the shadow values move into the live configuration registers in a single cycle, and both completion flags rise. On failure the live registers return to their reset defaults and both flags stay low. The address store keeps whatever was read in either case.

A separate 16-bit check over the address area is reported on its own flag and never affects acceptance. Software may start a fresh load, but only while the block is idle.

Top module: `cfg_autoload`

## Requirements
- R1: From reset release, and again after each accepted reload, the block reads EEPROM word addresses 0 to NUM_WORDS-1 (41 by default) exactly once each, in ascending order. busy_o is high from reset until the final verdict.
- R2: Each word transaction keeps ee_cs_o high throughout and lasts 25 rising edges of ee_sk_o. The block drives 9 command bits on ee_cmd_o, changing them only while ee_sk_o is low: a 1 start bit, the read code 1 then 0, and the 6-bit word address MSB first. It then samples ee_data_i on each of the next 16 rising edges.
- R3: Each half period of ee_sk_o lasts SK_HALF system clocks. Between transactions, ee_cs_o stays low for at least 2*SK_HALF clocks.
- R4: The first data bit sampled in a transaction lands in bit 15 of the stored word, and the last lands in bit 0.
- R5: Word w < 5 is stored in address word w (addr_words_o bits 16w+15:16w). Word w >= 5 is staged for configuration register w-5 (cfg_regs_o bits 16(w-5)+15:16(w-5)), so word 9 feeds register 4.
- R6: The image passes when the 8-bit sum of both bytes of all 41 words equals FFh. On a pass, done_o and valid_o go to 1 and every configuration register holds its loaded word, all at the same clock edge where busy_o falls.
- R7: On a fail, done_o and valid_o stay 0, every configuration register i returns to its default 16'hC000 + i, and the address words keep the values just read.
- R8: The configuration registers do not change while a load is in progress. They change only at the final verdict.
- R9: addr_sum_ok_o is 1 when the 16-bit sum of the high and low bytes of words 0 to 5 and 7 equals the 16-bit value of word 6. This result has no effect on valid_o.
- R10: With no EEPROM present (ee_data_i held at 1), the load takes the fail outcome of R7, and the address words read as FFFFh.
- R11: A reload_i pulse while busy_o is low starts a full new load and clears done_o and valid_o. A pulse while busy_o is high is ignored.
- R12: During reset, ee_cs_o, ee_sk_o, done_o, valid_o and addr_sum_ok_o are 0, busy_o is 1, the address words are 0, and the configuration registers hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 1 | Request for a new load; honoured only while idle |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_cmd_o | output | 1 | Command bits to the EEPROM |
| ee_data_i | input | 1 | Data bits from the EEPROM |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished with an accepted image |
| valid_o | output | 1 | Configuration contents are valid |
| addr_sum_ok_o | output | 1 | Result of the address-area check |
| addr_words_o | output | 16*ADDR_WORDS | Address store, word 0 in the low bits |
| cfg_regs_o | output | 16*(NUM_WORDS-ADDR_WORDS) | Live configuration registers, register 0 in the low bits |

## Verification
The bench serves several kinds of image from a model of the serial EEPROM:
- Random images with a correct adjust byte tell a pass apart from a fail.
- An image whose adjust byte is off by one bit shows that a single-bit error reverts every register while the address store is kept.
- A missing device (data held at 1) shows the all-ones case.

Images with and without a matching address-area word separate the reported 16-bit check from the enforced byte sum. A directed word at location 9, with only its top and bottom bits set, exposes a reversed bit order or a wrong register offset. The bench also snapshots the registers in the middle of a load, and sends a reload pulse during a load, to show that nothing leaks or restarts early.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;

  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    SER_IDLE,
    SER_SHIFT,
    SER_GAP
  } ser_st_e;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_ISSUE,
    LD_WAIT,
    LD_CHECK
  } ld_st_e;

  function automatic logic [WORD_W-1:0] cfg_default(int unsigned idx);
    return 16'hC000 + WORD_W'(idx);
  endfunction

endpackage

// File: rtl/ee_uwire_rd.sv
module ee_uwire_rd
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned SK_HALF = 4,
  parameter int unsigned AW      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  output logic              idle_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              cmd_o,
  input  logic              data_i
);

  localparam int unsigned CMD_W = 3 + AW;
  localparam int unsigned TOT_W = CMD_W + WORD_W;
  localparam int unsigned DIV_W = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;
  localparam int unsigned BIT_W = $clog2(TOT_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TOT_W - 1);
  localparam logic [BIT_W-1:0] BIT_DATA = BIT_W'(CMD_W);

  ser_st_e           st_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] shf_q;
  logic              sk_q, cs_q, gap_q, vld_q;
  logic              tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SER_IDLE;
      div_q <= '0;
      bit_q <= '0;
      cmd_q <= '0;
      shf_q <= '0;
      sk_q  <= 1'b0;
      cs_q  <= 1'b0;
      gap_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      div_q <= (st_q == SER_IDLE || tick) ? '0 : div_q + 1'b1;
      case (st_q)
        SER_IDLE: begin
          if (start_i) begin
            cs_q  <= 1'b1;
            sk_q  <= 1'b0;
            bit_q <= '0;
            cmd_q <= {3'b110, addr_i};
            st_q  <= SER_SHIFT;
          end
        end
        SER_SHIFT: begin
          if (tick) begin
            if (!sk_q) begin
              sk_q <= 1'b1;
              if (bit_q >= BIT_DATA) shf_q <= {shf_q[WORD_W-2:0], data_i};
            end else begin
              sk_q  <= 1'b0;
              cmd_q <= cmd_q << 1;
              if (bit_q == BIT_LAST) begin
                cs_q  <= 1'b0;
                gap_q <= 1'b0;
                vld_q <= 1'b1;
                st_q  <= SER_GAP;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        SER_GAP: begin
          if (tick) begin
            if (gap_q) st_q <= SER_IDLE;
            gap_q <= 1'b1;
          end
        end
        default: st_q <= SER_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == SER_IDLE);
  assign word_vld_o = vld_q;
  assign word_o     = shf_q;
  assign cs_o       = cs_q;
  assign sk_o       = sk_q;
  assign cmd_o      = cs_q & cmd_q[CMD_W-1];

  // R3
  sk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);

  // R2
  vld_after_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> !cs_o);

  // R3
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |=> !cs_o);

endmodule

// File: rtl/ld_csum.sv
module ld_csum
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned IW        = 6,
  parameter int unsigned ASUM_REF  = 6,
  parameter int unsigned ASUM_LAST = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [7:0]        sum_o,
  output logic              asum_ok_o
);

  logic [7:0]        sum_q;
  logic [WORD_W-1:0] asum_q, aref_q;
  logic [7:0]        hi_b, lo_b;

  assign hi_b = word_i[15:8];
  assign lo_b = word_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      asum_q <= '0;
      aref_q <= '0;
    end else if (clr_i) begin
      sum_q  <= '0;
      asum_q <= '0;
      aref_q <= '0;
    end else if (add_i) begin
      sum_q <= sum_q + hi_b + lo_b;
      if (idx_i == IW'(ASUM_REF)) aref_q <= word_i;
      else if (idx_i <= IW'(ASUM_LAST)) asum_q <= asum_q + {8'h00, hi_b} + {8'h00, lo_b};
    end
  end

  assign sum_o     = sum_q;
  assign asum_ok_o = (asum_q == aref_q);

  // R6
  sum_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_o == 8'h00));

endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned NUM_CFG = 36,
  parameter int unsigned CIW     = $clog2(NUM_CFG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      stage_we_i,
  input  logic [CIW-1:0]            stage_idx_i,
  input  logic [WORD_W-1:0]         stage_data_i,
  input  logic                      commit_i,
  input  logic                      revert_i,
  output logic [NUM_CFG*WORD_W-1:0] live_o
);

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    logic [WORD_W-1:0] shd_q, live_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q  <= cfg_default(g);
        live_q <= cfg_default(g);
      end else begin
        if (stage_we_i && stage_idx_i == CIW'(g)) shd_q <= stage_data_i;
        if (commit_i) live_q <= shd_q;
        else if (revert_i) live_q <= cfg_default(g);
      end
    end
    assign live_o[g*WORD_W +: WORD_W] = live_q;
  end

  // R8
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !revert_i) |=> $stable(live_o));

  // R7
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && revert_i));

endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned SK_HALF    = 4,
  parameter int unsigned NUM_WORDS  = 41,
  parameter int unsigned ADDR_WORDS = 5,
  parameter int unsigned EE_AW      = 6,
  parameter int unsigned ASUM_REF   = 6,
  parameter int unsigned ASUM_LAST  = 7
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     reload_i,
  output logic                                     ee_cs_o,
  output logic                                     ee_sk_o,
  output logic                                     ee_cmd_o,
  input  logic                                     ee_data_i,
  output logic                                     busy_o,
  output logic                                     done_o,
  output logic                                     valid_o,
  output logic                                     addr_sum_ok_o,
  output logic [ADDR_WORDS*WORD_W-1:0]             addr_words_o,
  output logic [(NUM_WORDS-ADDR_WORDS)*WORD_W-1:0] cfg_regs_o
);

  localparam int unsigned NUM_CFG = NUM_WORDS - ADDR_WORDS;
  localparam int unsigned IW      = $clog2(NUM_WORDS);
  localparam int unsigned CIW     = $clog2(NUM_CFG);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NUM_WORDS - 1);
  localparam logic [IW-1:0] ADDR_END  = IW'(ADDR_WORDS);
  localparam logic [7:0]    CSUM_GOOD = 8'hFF;

  function automatic logic [NUM_CFG*WORD_W-1:0] dflt_vec();
    logic [NUM_CFG*WORD_W-1:0] v;
    for (int i = 0; i < NUM_CFG; i++) v[i*WORD_W +: WORD_W] = cfg_default(i);
    return v;
  endfunction
  localparam logic [NUM_CFG*WORD_W-1:0] CFG_DFLT = dflt_vec();

  ld_st_e            st_q;
  logic [IW-1:0]     idx_q;
  logic              busy_q, done_q, valid_q, asum_ok_q;
  logic              eng_idle, eng_vld, eng_start;
  logic [WORD_W-1:0] eng_word;
  logic              word_take, reload_ok, pass, commit, revert;
  logic [7:0]        csum;
  logic              asum_ok;

  assign eng_start = (st_q == LD_ISSUE) && eng_idle;
  assign word_take = (st_q == LD_WAIT) && eng_vld;
  assign reload_ok = (st_q == LD_IDLE) && reload_i;
  assign pass      = (csum == CSUM_GOOD);
  assign commit    = (st_q == LD_CHECK) && pass;
  assign revert    = (st_q == LD_CHECK) && !pass;

  ee_uwire_rd #(
    .SK_HALF (SK_HALF),
    .AW      (EE_AW)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (eng_start),
    .addr_i     (EE_AW'(idx_q)),
    .idle_o     (eng_idle),
    .word_vld_o (eng_vld),
    .word_o     (eng_word),
    .cs_o       (ee_cs_o),
    .sk_o       (ee_sk_o),
    .cmd_o      (ee_cmd_o),
    .data_i     (ee_data_i)
  );

  ld_csum #(
    .IW        (IW),
    .ASUM_REF  (ASUM_REF),
    .ASUM_LAST (ASUM_LAST)
  ) u_csum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (reload_ok),
    .add_i     (word_take),
    .idx_i     (idx_q),
    .word_i    (eng_word),
    .sum_o     (csum),
    .asum_ok_o (asum_ok)
  );

  cfg_store #(
    .NUM_CFG (NUM_CFG),
    .CIW     (CIW)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stage_we_i   (word_take && (idx_q >= ADDR_END)),
    .stage_idx_i  (CIW'(idx_q - ADDR_END)),
    .stage_data_i (eng_word),
    .commit_i     (commit),
    .revert_i     (revert),
    .live_o       (cfg_regs_o)
  );

  // Address words are written directly; a failed verdict leaves them alone.
  for (genvar a = 0; a < ADDR_WORDS; a++) begin : g_addr
    logic [WORD_W-1:0] aw_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) aw_q <= '0;
      else if (word_take && idx_q == IW'(a)) aw_q <= eng_word;
    end
    assign addr_words_o[a*WORD_W +: WORD_W] = aw_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= LD_ISSUE;
      idx_q     <= '0;
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
      valid_q   <= 1'b0;
      asum_ok_q <= 1'b0;
    end else begin
      case (st_q)
        LD_IDLE: begin
          if (reload_i) begin
            busy_q    <= 1'b1;
            done_q    <= 1'b0;
            valid_q   <= 1'b0;
            asum_ok_q <= 1'b0;
            idx_q     <= '0;
            st_q      <= LD_ISSUE;
          end
        end
        LD_ISSUE: if (eng_idle) st_q <= LD_WAIT;
        LD_WAIT: begin
          if (eng_vld) begin
            if (idx_q == LAST_IDX) begin
              st_q <= LD_CHECK;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= LD_ISSUE;
            end
          end
        end
        LD_CHECK: begin
          busy_q    <= 1'b0;
          done_q    <= pass;
          valid_q   <= pass;
          asum_ok_q <= asum_ok;
          st_q      <= LD_IDLE;
        end
        default: st_q <= LD_IDLE;
      endcase
    end
  end

  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign valid_o       = valid_q;
  assign addr_sum_ok_o = asum_ok_q;

  // R6
  done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  // R11
  busy_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_o && !valid_o));

  // R7
  fail_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !valid_o) |-> (cfg_regs_o == CFG_DFLT));

  // R1
  idx_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);

  // R2
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start |-> !ee_cs_o);

endmodule

// File: tb/cfg_autoload_bench.sv
module cfg_autoload_bench;

  localparam int SKH    = 2;
  localparam int NW     = 41;
  localparam int NA     = 5;
  localparam int NC     = NW - NA;
  localparam int WD_LIM = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0;
  logic ee_cs, ee_sk, ee_cmd, ee_data;
  logic busy, done, valid, asum_ok;
  logic [NA*16-1:0] addr_w;
  logic [NC*16-1:0] cfg_w;

  always #5 clk = ~clk;

  cfg_autoload #(.SK_HALF(SKH)) u_cfg_autoload (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reload_i      (reload),
    .ee_cs_o       (ee_cs),
    .ee_sk_o       (ee_sk),
    .ee_cmd_o      (ee_cmd),
    .ee_data_i     (ee_data),
    .busy_o        (busy),
    .done_o        (done),
    .valid_o       (valid),
    .addr_sum_ok_o (asum_ok),
    .addr_words_o  (addr_w),
    .cfg_regs_o    (cfg_w)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // serial EEPROM model
  logic [15:0] mem [NW];
  logic        present = 1'b1;
  logic        ee_do = 1'b1;
  logic [15:0] cur_word = '1;
  logic [8:0]  cmd_sh = '0;
  int sk_cnt = 0, reads = 0, exp_addr = 0, addr_err = 0, cmd_err = 0;

  assign ee_data = present ? ee_do : 1'b1;

  always @(posedge ee_cs) begin
    sk_cnt = 0;
    cmd_sh = '0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      sk_cnt++;
      if (sk_cnt <= 9) cmd_sh = {cmd_sh[7:0], ee_cmd};
      if (sk_cnt == 9) begin
        if (cmd_sh[8:6] != 3'b110) cmd_err++;
        if (int'(cmd_sh[5:0]) != exp_addr) addr_err++;
        exp_addr++;
        cur_word = (int'(cmd_sh[5:0]) < NW) ? mem[cmd_sh[5:0]] : 16'hFFFF;
        reads++;
      end
      if (sk_cnt >= 9 && sk_cnt < 25) ee_do <= #1 cur_word[24 - sk_cnt];
      else ee_do <= #1 1'b1;
    end
  end

  // timing monitors (R3)
  int  half_cnt = 0, gap_cnt = 0, sk_err = 0, gap_err = 0;
  logic have_half = 1'b0, sk_prev = 1'b0, cs_prev = 1'b0, seen_fall = 1'b0;

  always @(negedge clk) begin
    cycles++;
    half_cnt++;
    if (!ee_cs) have_half = 1'b0;
    else if (ee_sk != sk_prev) begin
      if (have_half && half_cnt != SKH) sk_err++;
      have_half = 1'b1;
      half_cnt = 0;
    end
    if (!ee_cs && cs_prev) begin
      seen_fall = 1'b1;
      gap_cnt = 1;
    end else if (!ee_cs) gap_cnt++;
    if (ee_cs && !cs_prev && seen_fall && gap_cnt < 2*SKH) gap_err++;
    sk_prev = ee_sk;
    cs_prev = ee_cs;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] img_sum();
    logic [7:0] s = 8'h00;
    for (int w = 0; w < NW; w++) s = s + mem[w][15:8] + mem[w][7:0];
    return s;
  endfunction

  function automatic logic [15:0] img_asum();
    logic [15:0] s = 16'h0000;
    for (int w = 0; w <= 7; w++)
      if (w != 6) s = s + {8'h00, mem[w][15:8]} + {8'h00, mem[w][7:0]};
    return s;
  endfunction

  task automatic build_img(input bit asum_match);
    logic [7:0] s;
    for (int w = 0; w < NW; w++) mem[w] = 16'($urandom);
    mem[9] = 16'h8001;
    mem[6] = asum_match ? img_asum() : img_asum() + 16'h0001;
    mem[40][7:0] = 8'h00;
    s = img_sum();
    mem[40][7:0] = 8'hFF - s;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wait_reads(input int n);
    int k = 0;
    while (reads < n && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wait_load();
    int k = 0;
    while (busy && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk("R1 load finishes", {63'd0, busy}, 64'd0);
  endtask

  task automatic start_load();
    reads = 0;
    exp_addr = 0;
    addr_err = 0;
    cmd_err = 0;
    @(negedge clk) reload = 1'b1;
    @(negedge clk) reload = 1'b0;
    chk("R11 reload accepted while idle", {63'd0, busy}, 64'd1);
  endtask

  task automatic check_result(input string tag);
    bit pass = (img_sum() == 8'hFF);
    int bad = 0;
    logic [15:0] first_act = '0, first_exp = '0;
    chk({tag, " R1 word count"}, 64'(reads), 64'(NW));
    chk({tag, " R1 ascending addresses"}, 64'(addr_err), 64'd0);
    chk({tag, " R2 command bits"}, 64'(cmd_err), 64'd0);
    chk({tag, " R6 done"}, {63'd0, done}, {63'd0, pass});
    chk({tag, " R6 valid"}, {63'd0, valid}, {63'd0, pass});
    for (int i = 0; i < NC; i++) begin
      logic [15:0] e = pass ? mem[i + NA] : 16'hC000 + 16'(i);
      if (cfg_w[i*16 +: 16] !== e && bad == 0) begin
        first_act = cfg_w[i*16 +: 16];
        first_exp = e;
      end
      if (cfg_w[i*16 +: 16] !== e) bad++;
    end
    chk(pass ? {tag, " R6 loaded registers"} : {tag, " R7 default registers"},
        {48'd0, first_act}, {48'd0, first_exp});
    if (pass) chk({tag, " R4 R5 word 9 into register 4"}, {48'd0, cfg_w[4*16 +: 16]}, {48'd0, mem[9]});
    for (int a = 0; a < NA; a++)
      chk({tag, " R5 R7 address word"}, {48'd0, addr_w[a*16 +: 16]}, {48'd0, mem[a]});
    chk({tag, " R9 address check flag"}, {63'd0, asum_ok}, {63'd0, (img_asum() == mem[6])});
  endtask

  initial begin
    build_img(1'b1);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cs low", {63'd0, ee_cs}, 64'd0);
    chk("R12 sk low", {63'd0, ee_sk}, 64'd0);
    chk("R12 busy high", {63'd0, busy}, 64'd1);
    chk("R12 done/valid/asum low", {61'd0, done, valid, asum_ok}, 64'd0);
    chk("R12 address words zero", {{(64-NA*16+64){1'b0}}, addr_w} >> 0, 64'd0);
    chk("R12 register 0 default", {48'd0, cfg_w[15:0]}, 64'hC000);
    chk("R12 register 35 default", {48'd0, cfg_w[35*16 +: 16]}, 64'hC023);
    reads = 0;
    rst_n = 1'b1;
    // R8 during the first load the registers keep their defaults
    wait_reads(20);
    chk("R8 mid-load register 4", {48'd0, cfg_w[4*16 +: 16]}, 64'hC004);
    wait_load();
    check_result("good1");

    // bad adjust byte: single-bit error
    begin
      logic [15:0] snap;
      snap = cfg_w[4*16 +: 16];
      build_img(1'b1);
      mem[40][0] = ~mem[40][0];
      start_load();
      wait_reads(20);
      chk("R8 mid-load registers held", {48'd0, cfg_w[4*16 +: 16]}, {48'd0, snap});
      chk("R11 done cleared by reload", {62'd0, done, valid}, 64'd0);
      wait_load();
      check_result("badsum R7");
    end

    // address check mismatch, plus a reload pulse while busy
    build_img(1'b0);
    start_load();
    wait_reads(15);
    @(negedge clk) reload = 1'b1;
    @(negedge clk) reload = 1'b0;
    wait_load();
    check_result("asum-miss R9");
    repeat (200) @(negedge clk);
    chk("R11 busy reload ignored: no restart", {63'd0, busy}, 64'd0);
    chk("R11 busy reload ignored: read count", 64'(reads), 64'(NW));

    // no device present
    for (int w = 0; w < NW; w++) mem[w] = 16'hFFFF;
    present = 1'b0;
    start_load();
    wait_load();
    check_result("absent R10");
    chk("R10 fail outcome", {63'd0, valid}, 64'd0);
    present = 1'b1;

    // random good images
    for (int n = 0; n < 2; n++) begin
      build_img(n[0]);
      start_load();
      wait_load();
      check_result("random");
    end

    chk("R3 serial half period", 64'(sk_err), 64'd0);
    chk("R3 chip select gap", 64'(gap_err), 64'd0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    while (cycles < WD_LIM) @(negedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=%0d exp<%0d", cycles, WD_LIM);
    finish_run();
  end

endmodule